// File: doc/BRIEF.md
# DMA Channel Start and Arbitration Controller

This block chooses which channel of a small multi-channel DMA engine starts next, and it applies the global rules that can hold back new starts. Each channel raises a service request. When no channel is running and no stall condition holds, the arbiter selects one requester. It issues a single-cycle grant that carries the channel index. It then marks itself busy until the data-path engine reports that the minor loop is done. A channel that is already running is always allowed to finish. The stall conditions are the halt bit, halt caused by an error, and the debug stall.

A software control word holds five bits:
- halt (bit 0)
- halt-on-error (bit 1)
- round-robin enable (bit 2)
- debug-stall enable (bit 3)
- continuous link (bit 4)

Bits 7..5 are reserved. They always read as zero and ignore writes.

Software can also post a cancel command against the running channel. The controller waits for the engine to report the last write of the current read/write sequence. It then forces the minor loop to end and clears the command. The cancel is logged as an error. The error status holds a valid flag and the channel number of the most recent error, and it can raise an interrupt. When continuous link is on, a channel that is linked to itself restarts immediately at the end of its minor loop and does not re-enter arbitration.

Top module: `dma_start_ctrl`

## Requirements
- R1: While control bit 0 (halt) is 1, no new grant is issued. Grants resume after software clears the bit.
- R2: A channel that is already running stays busy under halt or debug stall until the engine reports done.
- R3: When control bit 1 (halt-on-error) is 1, an engine error or an honoured cancel sets control bit 0. Requests are then ignored until software clears bit 0.
- R4: When control bit 2 is 0, the arbiter grants the requesting channel with the highest index.
- R5: When control bit 2 is 1, the arbiter grants the first requesting channel found by searching upward, with wrap-around, from the channel after the last one granted. After reset, the last granted channel is the highest index.
- R6: When control bit 3 is 1 and the debug-mode input is high, no new grant is issued. When bit 3 is 0, the debug-mode input has no effect.
- R7: A cancel command raised while the block is busy sets the cancel-pending flag. The cancel is honoured only in a cycle where the sequence-end input is high. When honoured, the block pulses the cancel output for one cycle, the channel becomes idle, and the pending flag clears.
- R8: An honoured cancel sets the error valid flag and records the channel number. When the interrupt enable is 1, it also raises the error interrupt.
- R9: When control bit 4 (continuous link) is 0 and a self-linked channel completes, the block goes idle for one cycle and re-arbitrates. A higher-index requester then wins.
- R10: When control bit 4 is 1 and a self-linked channel completes with no stall, the block re-grants the same channel in the next cycle and stays busy, whatever other requests are present.
- R11: A grant lasts one cycle. A further grant requires that the engine reported done in the previous cycle.
- R12: An engine error while busy records the running channel and sets the error valid flag. A clear pulse resets the valid flag.
- R13: Control bits 7..5 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_CH | Per-channel service requests |
| link_self_i | input | NUM_CH | Per-channel minor-loop link-to-itself enables |
| ctl_wr_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 8 | Control word write data |
| ctl_rdata_o | output | 8 | Control word read-back |
| dbg_mode_i | input | 1 | System debug mode |
| cancel_req_i | input | 1 | Cancel-with-error command pulse |
| eng_seq_end_i | input | 1 | Engine finished the last write of a read/write sequence |
| eng_done_i | input | 1 | Engine finished the minor loop |
| eng_err_i | input | 1 | Engine error pulse |
| err_clr_i | input | 1 | Clear the error status |
| err_irq_en_i | input | 1 | Error interrupt enable |
| grant_o | output | 1 | One-cycle channel start pulse |
| grant_ch_o | output | CH_W | Granted channel index |
| busy_o | output | 1 | A channel is running |
| cancel_o | output | 1 | One-cycle forced minor-loop end |
| cancel_pend_o | output | 1 | Cancel command waiting to be honoured |
| err_valid_o | output | 1 | Error status valid |
| err_ch_o | output | CH_W | Channel of the most recent error |
| err_irq_o | output | 1 | Error interrupt |

## Verification
The assertions check the following on every cycle:
- No grant is issued from idle while halt is set.
- A running channel keeps busy until the engine ends it.
- A cancel never fires before a sequence end.
- An honoured cancel leaves an error logged and the block idle.
- A self-linked restart under continuous link re-grants the same channel.
- Halt-on-error sets halt.

The grant order under fixed and round-robin selection depends on the history of earlier grants, so only the bench scenarios show it. The same holds for the resumption of grants after halt or debug mode ends, the irrelevance of debug mode when its bit is off, and the reserved read-back.

// File: rtl/dma_sc_pkg.sv
package dma_sc_pkg;
  localparam int CTL_W   = 8;
  localparam int B_HALT  = 0;
  localparam int B_HOE   = 1;
  localparam int B_RR    = 2;
  localparam int B_DBG   = 3;
  localparam int B_CLINK = 4;
  localparam logic [CTL_W-1:0] CTL_MASK = 8'h1F;
endpackage

// File: rtl/dma_sc_ctl.sv
module dma_sc_ctl
  import dma_sc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [CTL_W-1:0] wdata_i,
  input  logic             err_evt_i,
  output logic [CTL_W-1:0] ctl_o
);
  logic [CTL_W-1:0] ctl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else begin
      if (wr_i) ctl_q <= wdata_i & CTL_MASK;
      // an error under halt-on-error overrides a same-cycle write of halt
      if (err_evt_i && ctl_q[B_HOE]) ctl_q[B_HALT] <= 1'b1;
    end
  end

  assign ctl_o = ctl_q;

  // R3
  hoe_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (err_evt_i && ctl_q[B_HOE]) |=> ctl_q[B_HALT]);
endmodule

// File: rtl/dma_sc_arb.sv
module dma_sc_arb #(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] req_i,
  input  logic              rr_en_i,
  input  logic [CH_W-1:0]   last_i,
  output logic              any_o,
  output logic [CH_W-1:0]   sel_o
);
  logic [CH_W-1:0] sel_fix;
  logic [CH_W-1:0] sel_rr;

  always_comb begin
    sel_fix = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (req_i[CH_W'(i)]) sel_fix = CH_W'(i);
    end
  end

  always_comb begin
    sel_rr = '0;
    for (int k = NUM_CH; k >= 1; k--) begin
      logic [CH_W-1:0] idx;
      idx = CH_W'((int'(last_i) + k) % NUM_CH);
      if (req_i[idx]) sel_rr = idx;
    end
  end

  assign any_o = |req_i;
  assign sel_o = rr_en_i ? sel_rr : sel_fix;
endmodule

// File: rtl/dma_sc_err.sv
module dma_sc_err #(
  parameter int CH_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            evt_i,
  input  logic [CH_W-1:0] evt_ch_i,
  input  logic            clr_i,
  input  logic            irq_en_i,
  output logic            valid_o,
  output logic [CH_W-1:0] ch_o,
  output logic            irq_o
);
  logic            valid_q, irq_q;
  logic [CH_W-1:0] ch_q;
  logic            valid_n;

  always_comb begin
    valid_n = valid_q;
    if (clr_i) valid_n = 1'b0;
    if (evt_i) valid_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      ch_q    <= '0;
      irq_q   <= 1'b0;
    end else begin
      valid_q <= valid_n;
      irq_q   <= valid_n & irq_en_i;
      if (evt_i) ch_q <= evt_ch_i;
      else if (clr_i) ch_q <= '0;
    end
  end

  assign valid_o = valid_q;
  assign ch_o    = ch_q;
  assign irq_o   = irq_q;

  // R12
  err_log_chk: assert property (@(posedge clk) disable iff (rst)
    evt_i |=> (valid_o && ch_o == $past(evt_ch_i)));
  // R12
  err_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !evt_i) |=> !valid_o);
endmodule

// File: rtl/dma_start_ctrl.sv
module dma_start_ctrl
  import dma_sc_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] req_i,
  input  logic [NUM_CH-1:0] link_self_i,
  input  logic              ctl_wr_i,
  input  logic [7:0]        ctl_wdata_i,
  output logic [7:0]        ctl_rdata_o,
  input  logic              dbg_mode_i,
  input  logic              cancel_req_i,
  input  logic              eng_seq_end_i,
  input  logic              eng_done_i,
  input  logic              eng_err_i,
  input  logic              err_clr_i,
  input  logic              err_irq_en_i,
  output logic              grant_o,
  output logic [CH_W-1:0]   grant_ch_o,
  output logic              busy_o,
  output logic              cancel_o,
  output logic              cancel_pend_o,
  output logic              err_valid_o,
  output logic [CH_W-1:0]   err_ch_o,
  output logic              err_irq_o
);
  logic [CTL_W-1:0] ctl_q;
  logic             active_q, grant_q, cancel_q, pend_q;
  logic [CH_W-1:0]  act_ch_q, last_q, grant_ch_q;
  logic             arb_any;
  logic [CH_W-1:0]  arb_sel;
  logic             stall, honour, err_evt, restart, start, end_now;

  dma_sc_ctl u_ctl (
    .clk(clk), .rst(rst), .wr_i(ctl_wr_i), .wdata_i(ctl_wdata_i),
    .err_evt_i(err_evt), .ctl_o(ctl_q)
  );

  dma_sc_arb #(.NUM_CH(NUM_CH)) u_arb (
    .req_i(req_i), .rr_en_i(ctl_q[B_RR]), .last_i(last_q),
    .any_o(arb_any), .sel_o(arb_sel)
  );

  dma_sc_err #(.CH_W(CH_W)) u_err (
    .clk(clk), .rst(rst), .evt_i(err_evt), .evt_ch_i(act_ch_q),
    .clr_i(err_clr_i), .irq_en_i(err_irq_en_i),
    .valid_o(err_valid_o), .ch_o(err_ch_o), .irq_o(err_irq_o)
  );

  assign stall   = ctl_q[B_HALT] | (ctl_q[B_DBG] & dbg_mode_i);
  assign honour  = active_q & pend_q & eng_seq_end_i;
  assign err_evt = honour | (active_q & eng_err_i);
  assign restart = active_q & eng_done_i & ~honour & ctl_q[B_CLINK]
                 & link_self_i[act_ch_q] & ~stall;
  assign start   = ~active_q & ~stall & arb_any;
  assign end_now = active_q & (honour | (eng_done_i & ~restart));

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q   <= 1'b0;
      act_ch_q   <= '0;
      last_q     <= CH_W'(NUM_CH - 1);
      grant_q    <= 1'b0;
      grant_ch_q <= '0;
      cancel_q   <= 1'b0;
      pend_q     <= 1'b0;
    end else begin
      grant_q  <= start | restart;
      cancel_q <= honour;
      if (start) begin
        active_q   <= 1'b1;
        act_ch_q   <= arb_sel;
        last_q     <= arb_sel;
        grant_ch_q <= arb_sel;
      end else if (restart) begin
        grant_ch_q <= act_ch_q;
      end else if (end_now) begin
        active_q <= 1'b0;
      end
      if (end_now) pend_q <= 1'b0;
      else if (cancel_req_i && active_q) pend_q <= 1'b1;
    end
  end

  assign ctl_rdata_o   = ctl_q;
  assign grant_o       = grant_q;
  assign grant_ch_o    = grant_ch_q;
  assign busy_o        = active_q;
  assign cancel_o      = cancel_q;
  assign cancel_pend_o = pend_q;

  // R1
  halt_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && ctl_rdata_o[B_HALT]) |=> !grant_o);
  // R2
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !eng_done_i && !eng_seq_end_i) |=> busy_o);
  // R7
  cancel_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (cancel_pend_o && !eng_seq_end_i) |=> !cancel_o);
  // R8
  cancel_log_chk: assert property (@(posedge clk) disable iff (rst)
    cancel_o |-> (err_valid_o && !busy_o && !cancel_pend_o));
  // R10
  clink_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && eng_done_i && !cancel_pend_o && ctl_rdata_o[B_CLINK]
     && link_self_i[act_ch_q] && !ctl_rdata_o[B_HALT]
     && !(ctl_rdata_o[B_DBG] && dbg_mode_i))
    |=> (grant_o && busy_o && grant_ch_o == $past(act_ch_q)));
  // R11
  grant_once_chk: assert property (@(posedge clk) disable iff (rst)
    grant_o |=> (!grant_o || $past(eng_done_i)));
endmodule

// File: tb/dma_start_ctrl_tb.sv
module dma_start_ctrl_tb_top;
  localparam int NUM_CH = 4;
  localparam int CH_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NUM_CH-1:0] req = '0, link_self = '0;
  logic ctl_wr = 0; logic [7:0] ctl_wdata = '0; logic [7:0] ctl_rdata;
  logic dbg_mode = 0, cancel_req = 0, seq_end = 0, done = 0, eng_err = 0;
  logic err_clr = 0, irq_en = 0;
  logic grant, busy, cancel, pend, err_valid, err_irq;
  logic [CH_W-1:0] grant_ch, err_ch;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_start_ctrl #(.NUM_CH(NUM_CH)) dut_i (
    .clk(clk), .rst(rst), .req_i(req), .link_self_i(link_self),
    .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata), .ctl_rdata_o(ctl_rdata),
    .dbg_mode_i(dbg_mode), .cancel_req_i(cancel_req),
    .eng_seq_end_i(seq_end), .eng_done_i(done), .eng_err_i(eng_err),
    .err_clr_i(err_clr), .err_irq_en_i(irq_en),
    .grant_o(grant), .grant_ch_o(grant_ch), .busy_o(busy),
    .cancel_o(cancel), .cancel_pend_o(pend), .err_valid_o(err_valid),
    .err_ch_o(err_ch), .err_irq_o(err_irq)
  );

  // vector: {round-robin, request mask, expected channel}
  localparam logic [6:0] VEC [8] = '{
    {1'b0, 4'b0101, 2'd2},  // R4
    {1'b0, 4'b1111, 2'd3},  // R4
    {1'b1, 4'b1111, 2'd0},  // R5 after last=3
    {1'b1, 4'b1111, 2'd1},  // R5
    {1'b1, 4'b1001, 2'd3},  // R5
    {1'b1, 4'b1001, 2'd0},  // R5 wrap
    {1'b0, 4'b0011, 2'd1},  // R4
    {1'b0, 4'b0001, 2'd0}   // R4
  };

  task automatic tick(); @(negedge clk); endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_ctl(logic [7:0] v);
    ctl_wr = 1; ctl_wdata = v; tick(); ctl_wr = 0;
  endtask

  task automatic wait_grant(output logic [CH_W-1:0] ch, output bit seen);
    seen = 0; ch = '0;
    for (int n = 0; n < 20; n++) begin
      tick();
      if (grant) begin seen = 1; ch = grant_ch; break; end
    end
  endtask

  task automatic pulse_done();
    done = 1; tick(); done = 0;
  endtask

  task automatic no_grant_for(string tag, int n);
    bit g = 0;
    for (int i = 0; i < n; i++) begin tick(); if (grant) g = 1; end
    check(tag, {31'd0, g}, 32'd0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [CH_W-1:0] ch;
    bit seen;
    repeat (3) tick();
    rst = 0;
    tick();
    check("reset grant", {31'd0, grant}, 0);
    check("reset busy", {31'd0, busy}, 0);
    check("reset ctl", {24'd0, ctl_rdata}, 0);
    check("reset err", {31'd0, err_valid}, 0);

    // R4 R5 R11 vector table
    for (int v = 0; v < 8; v++) begin
      write_ctl({5'd0, VEC[v][6], 2'd0});
      req = VEC[v][5:2];
      wait_grant(ch, seen);
      check($sformatf("R4/R5 vec%0d seen", v), {31'd0, seen}, 1);
      check($sformatf("R4/R5 vec%0d ch", v), {30'd0, ch}, {30'd0, VEC[v][1:0]});
      tick();
      check("R11 single grant", {31'd0, grant}, 0);
      check("R11 busy", {31'd0, busy}, 1);
      req = '0;
      pulse_done();
      tick();
    end

    // R13 reserved bits
    write_ctl(8'hFF);
    check("R13 reserved read", {24'd0, ctl_rdata}, 32'h1F);
    write_ctl(8'h00);

    // R1 R2 halt
    req = 4'b0100;
    wait_grant(ch, seen);
    check("R1 pre-halt grant", {30'd0, ch}, 2);
    req = 4'b1111;
    write_ctl(8'h01);
    repeat (3) tick();
    check("R2 running under halt", {31'd0, busy}, 1);
    pulse_done();
    check("R2 done ends", {31'd0, busy}, 0);
    no_grant_for("R1 halt blocks", 6);
    write_ctl(8'h00);
    wait_grant(ch, seen);
    check("R1 resume", {31'd0, seen}, 1);
    req = '0; tick(); pulse_done(); tick();

    // R6 debug stall
    write_ctl(8'h08); dbg_mode = 1; req = 4'b0001;
    no_grant_for("R6 debug stall", 6);
    dbg_mode = 0;
    wait_grant(ch, seen);
    check("R6 resume on exit", {31'd0, seen}, 1);
    req = '0; tick(); pulse_done(); tick();
    write_ctl(8'h00); dbg_mode = 1; req = 4'b0001;
    wait_grant(ch, seen);
    check("R6 no effect when off", {31'd0, seen}, 1);
    req = '0; tick(); pulse_done(); dbg_mode = 0; tick();

    // R7 R8 cancel
    irq_en = 1; req = 4'b0100;
    wait_grant(ch, seen);
    req = '0; tick();
    cancel_req = 1; tick(); cancel_req = 0;
    check("R7 pending set", {31'd0, pend}, 1);
    repeat (3) tick();
    check("R7 not before seq end", {31'd0, cancel}, 0);
    check("R7 still busy", {31'd0, busy}, 1);
    seq_end = 1; tick(); seq_end = 0;
    check("R7 cancel pulse", {31'd0, cancel}, 1);
    check("R7 idle", {31'd0, busy}, 0);
    check("R7 pending cleared", {31'd0, pend}, 0);
    check("R8 err valid", {31'd0, err_valid}, 1);
    check("R8 err ch", {30'd0, err_ch}, 2);
    check("R8 irq", {31'd0, err_irq}, 1);
    tick();
    check("R7 cancel one cycle", {31'd0, cancel}, 0);
    err_clr = 1; tick(); err_clr = 0;
    check("R12 clear", {31'd0, err_valid}, 0);
    irq_en = 0;

    // R3 R12 halt on error
    write_ctl(8'h02); req = 4'b0010;
    wait_grant(ch, seen);
    eng_err = 1; tick(); eng_err = 0;
    check("R3 halt set", {31'd0, ctl_rdata[0]}, 1);
    check("R12 err valid", {31'd0, err_valid}, 1);
    check("R12 err ch", {30'd0, err_ch}, 1);
    pulse_done();
    no_grant_for("R3 requests ignored", 6);
    write_ctl(8'h00);
    wait_grant(ch, seen);
    check("R3 resume", {31'd0, seen}, 1);
    req = '0; tick(); pulse_done(); tick();
    err_clr = 1; tick(); err_clr = 0;

    // R10 continuous link restart
    write_ctl(8'h10); link_self = 4'b0001; req = 4'b0001;
    wait_grant(ch, seen);
    req = 4'b1001; tick();
    pulse_done();
    check("R10 regrant", {31'd0, grant}, 1);
    check("R10 same ch", {30'd0, grant_ch}, 0);
    check("R10 busy", {31'd0, busy}, 1);

    // R9 link through arbitration
    write_ctl(8'h00);
    pulse_done();
    check("R9 idle gap grant", {31'd0, grant}, 0);
    check("R9 idle gap busy", {31'd0, busy}, 0);
    tick();
    check("R9 rearb grant", {31'd0, grant}, 1);
    check("R9 rearb ch", {30'd0, grant_ch}, 3);
    req = '0; tick(); pulse_done(); tick();

    finish_run();
  end
endmodule